// File: doc/BRIEF.md
# Dual-Mode JTAG Test Access Port

This block is a JTAG test access port that serves two logical controllers through a single set of TCK, TMS, TDI, TDO and TRST pins. After TRST the port is in boundary-scan mode, where a 3-bit instruction register selects one of two data paths. The first is a boundary register of `NCELL` cells, used by EXTEST and SAMPLE/PRELOAD. The second is a one-bit bypass register. Each boundary cell sits between a core output and a pin output. A cell samples the pin input during capture, and its update stage drives the pin only while EXTEST is active.

Loading a dedicated switchover instruction gives the port to a debug personality. In debug mode every data-register scan addresses a 2-bit request register. On Update-DR its two bits become a one-TCK-cycle chip-reset request and a one-TCK-cycle interrupt request. Only TRST returns the port to boundary-scan mode.

Top module: `dmtap_top`

## Requirements
- R1: The controller follows the standard 16-state TAP state machine, advanced on the rising edge of TCK. Five consecutive TCK rising edges with TMS high reach Test-Logic-Reset from any state, and this clears a loaded EXTEST so that the pins pass core data again.
- R2: While TRST is low, and after it is released, the port is in boundary-scan mode with the BYPASS instruction. In this state TDO is not driven, no request output is high, and `pin_out` equals `core_out`. Entering Test-Logic-Reset also reloads BYPASS.
- R3: The instruction register is 3 bits wide and is shifted with the least significant bit first. Capture-IR loads 3'b001, so a 3-bit IR scan returns 3'b001. The new instruction takes effect on the falling edge of TCK in Update-IR.
- R4: In boundary-scan mode, code 3'b000 (EXTEST) and code 3'b001 (SAMPLE/PRELOAD) select the boundary register. Code 3'b111 (BYPASS) and the undefined codes 3'b010, 3'b011, 3'b100 and 3'b110 select a 1-bit bypass register that captures 0. A DR scan through the bypass register returns the TDI data delayed by one bit.
- R5: The boundary register captures `pin_in[i]` into cell i. During shifting, TDI enters cell NCELL-1 and cell 0 drives TDO. Its update stage loads the shift stage on the falling edge of TCK in Update-DR, under both EXTEST and SAMPLE/PRELOAD.
- R6: When EXTEST is the active instruction in boundary-scan mode, `pin_out` shows the update stage. In every other case `pin_out` equals `core_out`.
- R7: TDO changes on the falling edge of TCK. `tdo_oe` is high exactly while the controller is in Shift-DR or Shift-IR.
- R8: In boundary-scan mode, an Update-IR with code 3'b101 switches the port to debug mode. Debug mode survives Test-Logic-Reset and is left only through TRST.
- R9: In debug mode every DR scan addresses a 2-bit request register, whatever the instruction, and that register captures 2'b00. On Update-DR, bit 0 produces a one-TCK-cycle pulse on `dbg_rst_req` and bit 1 produces a one-TCK-cycle pulse on `dbg_irq_req`. EXTEST has no effect on the pins in this mode.
- R10: Neither request output ever goes high in boundary-scan mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, asynchronous assertion |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, changes on the falling edge |
| tdo_oe | output | 1 | Output enable for TDO |
| core_out | input | NCELL | Core-side output values |
| pin_in | input | NCELL | Values observed at the pins |
| pin_out | output | NCELL | Values driven to the pins |
| dbg_rst_req | output | 1 | Debug chip-reset request pulse |
| dbg_irq_req | output | 1 | Debug interrupt request pulse |

## Verification
The bench builds the block with `NCELL` = 4 and always scans 8 data bits. Every boundary scan therefore pushes TDI data through the whole chain and back out at TDO. This separates the 4-cell path from the 1-cell bypass path in a single readout, and it also shows which cells land in the update stage. The bench drives `core_out` and `pin_in` with different values, so pass-through, capture and EXTEST drive each leave their own mark on the pins.

// File: rtl/dmtap_pkg.sv
package dmtap_pkg;
  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SELDR, S_CAPDR, S_SHDR, S_EX1DR, S_PADR, S_EX2DR, S_UPDR,
    S_SELIR, S_CAPIR, S_SHIR, S_EX1IR, S_PAIR, S_EX2IR, S_UPIR
  } tap_state_e;

  localparam int unsigned IR_W = 3;
  localparam logic [IR_W-1:0] OP_EXTEST   = 3'b000;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 3'b001;
  localparam logic [IR_W-1:0] OP_HANDOVER = 3'b101;
  localparam logic [IR_W-1:0] OP_BYPASS   = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 3'b001;
  localparam int unsigned REQ_W = 2;
endpackage

// File: rtl/dmtap_fsm.sv
module dmtap_fsm
  import dmtap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      S_TLR:   nxt = tms ? S_TLR   : S_RTI;
      S_RTI:   nxt = tms ? S_SELDR : S_RTI;
      S_SELDR: nxt = tms ? S_SELIR : S_CAPDR;
      S_CAPDR: nxt = tms ? S_EX1DR : S_SHDR;
      S_SHDR:  nxt = tms ? S_EX1DR : S_SHDR;
      S_EX1DR: nxt = tms ? S_UPDR  : S_PADR;
      S_PADR:  nxt = tms ? S_EX2DR : S_PADR;
      S_EX2DR: nxt = tms ? S_UPDR  : S_SHDR;
      S_UPDR:  nxt = tms ? S_SELDR : S_RTI;
      S_SELIR: nxt = tms ? S_TLR   : S_CAPIR;
      S_CAPIR: nxt = tms ? S_EX1IR : S_SHIR;
      S_SHIR:  nxt = tms ? S_EX1IR : S_SHIR;
      S_EX1IR: nxt = tms ? S_UPIR  : S_PAIR;
      S_PAIR:  nxt = tms ? S_EX2IR : S_PAIR;
      S_EX2IR: nxt = tms ? S_UPIR  : S_SHIR;
      S_UPIR:  nxt = tms ? S_SELDR : S_RTI;
      default: nxt = S_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= S_TLR;
    else        state <= nxt;
  end
endmodule

// File: rtl/dmtap_ir.sv
module dmtap_ir
  import dmtap_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_so,
  output logic            dbg_mode
);
  logic [IR_W-1:0] sr_q;
  logic            cap_en, sh_en, upd_en;

  assign cap_en = (state == S_CAPIR);
  assign sh_en  = (state == S_SHIR);
  assign upd_en = (state == S_UPIR);
  assign ir_so  = sr_q[0];

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      sr_q <= IR_CAPTURE;
    else if (cap_en) sr_q <= IR_CAPTURE;
    else if (sh_en)  sr_q <= {tdi, sr_q[IR_W-1:1]};
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_q     <= OP_BYPASS;
      dbg_mode <= 1'b0;
    end else if (state == S_TLR) begin
      ir_q <= OP_BYPASS;
    end else if (upd_en) begin
      ir_q <= sr_q;
      if (sr_q == OP_HANDOVER) dbg_mode <= 1'b1;
    end
  end
endmodule

// File: rtl/dmtap_bsr.sv
module dmtap_bsr
  import dmtap_pkg::*;
#(
  parameter int unsigned NCELL = 4
) (
  input  logic             tck,
  input  logic             rst_n,
  input  tap_state_e       state,
  input  logic             sel,
  input  logic             extest,
  input  logic             tdi,
  input  logic [NCELL-1:0] pin_in,
  input  logic [NCELL-1:0] core_out,
  output logic             so,
  output logic [NCELL-1:0] pin_out
);
  logic [NCELL-1:0] sh_q, upd_q;
  logic             cap_en, sh_en, upd_en;

  assign cap_en = sel && (state == S_CAPDR);
  assign sh_en  = sel && (state == S_SHDR);
  assign upd_en = sel && (state == S_UPDR);
  assign so     = sh_q[0];

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      sh_q <= '0;
    else if (cap_en) sh_q <= pin_in;
    else if (sh_en)  sh_q <= {tdi, sh_q[NCELL-1:1]};
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)      upd_q <= '0;
    else if (upd_en) upd_q <= sh_q;
  end

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    assign pin_out[i] = extest ? upd_q[i] : core_out[i];
  end
endmodule

// File: rtl/dmtap_reqreg.sv
module dmtap_reqreg
  import dmtap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_e state,
  input  logic       sel,
  input  logic       tdi,
  output logic       so,
  output logic       rst_req,
  output logic       irq_req
);
  logic [REQ_W-1:0] sh_q;
  logic             cap_en, sh_en, upd_en;

  assign cap_en = sel && (state == S_CAPDR);
  assign sh_en  = sel && (state == S_SHDR);
  assign upd_en = sel && (state == S_UPDR);
  assign so     = sh_q[0];

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      sh_q <= '0;
    else if (cap_en) sh_q <= '0;
    else if (sh_en)  sh_q <= {tdi, sh_q[REQ_W-1:1]};
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
      irq_req <= 1'b0;
    end else begin
      rst_req <= upd_en && sh_q[0];
      irq_req <= upd_en && sh_q[1];
    end
  end
endmodule

// File: rtl/dmtap_top.sv
module dmtap_top
  import dmtap_pkg::*;
#(
  parameter int unsigned NCELL = 4
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_oe,
  input  logic [NCELL-1:0] core_out,
  input  logic [NCELL-1:0] pin_in,
  output logic [NCELL-1:0] pin_out,
  output logic             dbg_rst_req,
  output logic             dbg_irq_req
);
  logic [1:0]      rst_sync_q;
  logic            rst_n;
  tap_state_e      state;
  logic [IR_W-1:0] ir_q;
  logic            ir_so, dbg_mode;
  logic            extest, bsr_sel, byp_sel;
  logic            bsr_so, req_so, byp_q, dr_so;

  // asynchronous assertion, release aligned to TCK
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  dmtap_fsm u_fsm (.tck(tck), .rst_n(rst_n), .tms(tms), .state(state));

  dmtap_ir u_ir (
    .tck(tck), .rst_n(rst_n), .state(state), .tdi(tdi),
    .ir_q(ir_q), .ir_so(ir_so), .dbg_mode(dbg_mode)
  );

  assign extest  = !dbg_mode && (ir_q == OP_EXTEST);
  assign bsr_sel = !dbg_mode && ((ir_q == OP_EXTEST) || (ir_q == OP_SAMPLE));
  assign byp_sel = !dbg_mode && !bsr_sel;

  dmtap_bsr #(.NCELL(NCELL)) u_bsr (
    .tck(tck), .rst_n(rst_n), .state(state), .sel(bsr_sel), .extest(extest),
    .tdi(tdi), .pin_in(pin_in), .core_out(core_out), .so(bsr_so), .pin_out(pin_out)
  );

  dmtap_reqreg u_req (
    .tck(tck), .rst_n(rst_n), .state(state), .sel(dbg_mode), .tdi(tdi),
    .so(req_so), .rst_req(dbg_rst_req), .irq_req(dbg_irq_req)
  );

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                            byp_q <= 1'b0;
    else if (byp_sel && state == S_CAPDR)  byp_q <= 1'b0;
    else if (byp_sel && state == S_SHDR)   byp_q <= tdi;
  end

  always_comb begin
    if (dbg_mode)     dr_so = req_so;
    else if (bsr_sel) dr_so = bsr_so;
    else              dr_so = byp_q;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (state == S_SHIR) || (state == S_SHDR);
      if (state == S_SHIR)      tdo <= ir_so;
      else if (state == S_SHDR) tdo <= dr_so;
    end
  end
endmodule

// File: rtl/dmtap_chk.sv
module dmtap_chk
  import dmtap_pkg::*;
#(
  parameter int unsigned NCELL = 4
) (
  input logic             tck,
  input logic             rst_n,
  input logic             tms,
  input tap_state_e       state,
  input logic             dbg_mode,
  input logic [IR_W-1:0]  ir_q,
  input logic             tdo_oe,
  input logic [NCELL-1:0] core_out,
  input logic [NCELL-1:0] pin_out,
  input logic             dbg_rst_req,
  input logic             dbg_irq_req
);
  logic [2:0] hi_cnt;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)               hi_cnt <= '0;
    else if (!tms)            hi_cnt <= '0;
    else if (hi_cnt != 3'd7)  hi_cnt <= hi_cnt + 3'd1;
  end

  a_r1_five_high_reset: assert property (@(posedge tck) disable iff (!rst_n)
    (hi_cnt >= 3'd5) |-> (state == S_TLR));

  a_r7_oe_window: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe == ((state == S_SHDR) || (state == S_SHIR)));

  a_r6_pass_through: assert property (@(posedge tck) disable iff (!rst_n)
    !(!dbg_mode && ir_q == OP_EXTEST) |-> (pin_out == core_out));

  a_r9_rst_one_cycle: assert property (@(posedge tck) disable iff (!rst_n)
    dbg_rst_req |=> !dbg_rst_req);

  a_r9_irq_one_cycle: assert property (@(posedge tck) disable iff (!rst_n)
    dbg_irq_req |=> !dbg_irq_req);

  a_r10_req_needs_mode: assert property (@(posedge tck) disable iff (!rst_n)
    (dbg_rst_req || dbg_irq_req) |-> dbg_mode);

  always @(posedge tck) begin
    if (!rst_n) begin
      a_r8_trst_leaves_debug: assert (!dbg_mode);
    end
  end
endmodule

bind dmtap_top dmtap_chk #(.NCELL(NCELL)) u_chk (
  .tck(tck), .rst_n(rst_n), .tms(tms), .state(state), .dbg_mode(dbg_mode),
  .ir_q(ir_q), .tdo_oe(tdo_oe), .core_out(core_out), .pin_out(pin_out),
  .dbg_rst_req(dbg_rst_req), .dbg_irq_req(dbg_irq_req)
);

// File: tb/tb_dmtap_top.sv
module tb_dmtap_top;
  localparam int N = 4;
  localparam int NV = 6;
  // {op, pin_in, core_out, tdi data, expected tdo data, expected pin_out}
  localparam logic [30:0] VEC [NV] = '{
    {3'b000, 4'hA, 4'h6, 8'hC3, 8'h3A, 4'hC},
    {3'b001, 4'h5, 4'h9, 8'hF0, 8'h05, 4'h9},
    {3'b111, 4'hF, 4'h3, 8'hB6, 8'h6C, 4'h3},
    {3'b010, 4'h0, 4'hE, 8'h81, 8'h02, 4'hE},
    {3'b000, 4'h3, 4'h0, 8'h5A, 8'hA3, 4'h5},
    {3'b110, 4'h7, 4'h5, 8'hFF, 8'hFE, 4'h5}
  };

  logic tck = 1'b0;
  logic trst_n, tms, tdi;
  logic [N-1:0] core_out, pin_in, pin_out;
  logic tdo, tdo_oe, dbg_rst_req, dbg_irq_req;

  dmtap_top #(.NCELL(N)) dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .core_out(core_out), .pin_in(pin_in), .pin_out(pin_out),
    .dbg_rst_req(dbg_rst_req), .dbg_irq_req(dbg_irq_req)
  );

  always #5 tck = ~tck;

  int n_chk = 0, n_bad = 0;
  logic s_tdo, s_oe, s_rst, s_irq;
  logic [N-1:0] s_pins;
  logic p_rst, p_irq, q_rst, q_irq, oe_all;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    @(negedge tck);
    #1;
    tms = m;
    tdi = d;
    #3;
    s_tdo = tdo; s_oe = tdo_oe; s_rst = dbg_rst_req; s_irq = dbg_irq_req; s_pins = pin_out;
    @(posedge tck);
  endtask

  task automatic shift_ir(input logic [2:0] op, output logic [2:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, op[i]);
      cap[i] = s_tdo;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic shift_dr(input int n, input logic [15:0] d, output logic [15:0] q);
    q = '0;
    oe_all = 1'b1;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, d[i]);
      q[i] = s_tdo;
      oe_all = oe_all & s_oe;
    end
    step(1, 0);
    step(0, 0); p_rst = s_rst; p_irq = s_irq;
    step(0, 0); q_rst = s_rst; q_irq = s_irq;
  endtask

  task automatic do_trst();
    trst_n = 1'b0;
    tms = 1'b1; tdi = 1'b0;
    repeat (3) @(posedge tck);
    @(negedge tck);
    trst_n = 1'b1;
    repeat (3) step(1, 0);
    step(0, 0);
  endtask

  bit finished = 0;

  initial begin
    #2000000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0]  cap;
    logic [15:0] q;
    core_out = 4'h2; pin_in = 4'h0;
    do_trst();
    // R2: reset state
    check("R2 oe after reset", s_oe, 0);
    check("R2 pins after reset", s_pins, core_out);
    check("R2 no request after reset", {s_rst, s_irq}, 0);
    shift_dr(8, 16'h00A5, q);
    check("R2 bypass default", q[7:0], 8'h4A);
    check("R7 oe during shift", oe_all, 1);
    check("R7 oe idle", s_oe, 0);
    check("R10 no request in boundary mode", {p_rst, p_irq, q_rst, q_irq}, 0);

    // table walk: R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      logic [30:0] e;
      e = VEC[v];
      pin_in = e[27:24];
      core_out = e[23:20];
      shift_ir(e[30:28], cap);
      check("R3 IR capture", cap, 3'b001);
      shift_dr(8, {8'h00, e[19:12]}, q);
      check("R4 R5 scan data", q[7:0], e[11:4]);
      check("R6 pins after update", s_pins, e[3:0]);
    end

    // R1: five TMS highs leave EXTEST
    core_out = 4'h2;
    shift_ir(3'b000, cap);
    shift_dr(8, 16'h0090, q);
    check("R6 EXTEST drives pins", s_pins, 4'h9);
    repeat (5) step(1, 0);
    step(0, 0);
    check("R1 TLR restores pass-through", s_pins, 4'h2);
    shift_dr(8, 16'h0001, q);
    check("R1 bypass after TLR", q[7:0], 8'h02);

    // R10: all-ones DR scan in boundary mode
    shift_dr(8, 16'h00FF, q);
    check("R10 no request under bypass", {p_rst, p_irq}, 0);

    // R8 R9: switchover
    shift_ir(3'b101, cap);
    check("R3 capture before switchover", cap, 3'b001);
    shift_dr(2, 16'h0001, q);
    check("R9 capture zero", q[1:0], 2'b00);
    check("R9 reset pulse", {p_rst, p_irq}, 2'b10);
    check("R9 pulse ends", {q_rst, q_irq}, 2'b00);
    shift_dr(2, 16'h0002, q);
    check("R9 irq pulse", {p_rst, p_irq}, 2'b01);
    check("R9 irq ends", {q_rst, q_irq}, 2'b00);
    shift_dr(2, 16'h0003, q);
    check("R9 both pulses", {p_rst, p_irq}, 2'b11);
    shift_ir(3'b000, cap);
    shift_dr(2, 16'h0001, q);
    check("R9 request reg under EXTEST code", {p_rst, p_irq}, 2'b10);
    check("R9 EXTEST ignored at pins", s_pins, core_out);
    repeat (5) step(1, 0);
    step(0, 0);
    shift_dr(2, 16'h0002, q);
    check("R8 debug survives TLR", {p_rst, p_irq}, 2'b01);

    // R8: TRST returns to boundary mode
    do_trst();
    check("R2 oe after TRST", s_oe, 0);
    shift_dr(8, 16'h00FF, q);
    check("R8 bypass after TRST", q[7:0], 8'hFE);
    check("R10 no request after TRST", {p_rst, p_irq, q_rst, q_irq}, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule